// File: doc/BRIEF.md
# Eligible Warp Issue Scheduler

This block picks, once per clock, which warp of a compute unit sends its next instruction into the execution pipeline. It holds a fixed pool of warp slots. A slot becomes live when an allocate request binds a warp and its owning block tag to it. The slot stays live until a retire request frees it.

Each live warp reports three stall causes every cycle: instruction fetch pending, data dependency and execution unit busy. A warp can also report that it has reached a block barrier. A warp that is live, has no stall cause raised and is not parked at a barrier is eligible.

The block grants the issue slot by round robin among eligible warps. The search starts just after the warp that issued last. The execution path is pipelined, so a warp that issued in one cycle may issue again in the next. Barrier parking is grouped by block tag only. Once every live warp carrying a tag has arrived, all of those warps are released together.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, no slot is live, `issue_valid` is 0 and `bar_release` is all zeros.
- R2: An allocate request to a slot that is not live makes that slot live with the given block tag from the next cycle. An allocate request to a slot that is already live is ignored, and the slot keeps its original block tag.
- R3: A retire request frees its slot from the next cycle. A retired warp is never issued again until it is reallocated, and it no longer counts toward any barrier.
- R4: A warp is eligible only if it is live, none of `stall_fetch`, `stall_data` or `stall_exec` is 1 for it in that cycle, it is not raising `bar_arrive`, and it is not parked at a barrier. Any single stall flag on its own is enough to block the warp.
- R5: At most one warp issues per cycle. `issue_valid` is 0 in every cycle in which no warp is eligible.
- R6: Among eligible warps, the granted warp is the first one found when counting upward by slot index, with wraparound, starting one past the last warp that issued. An idle cycle does not move this starting point. Before the first issue after reset, the search begins at slot 0.
- R7: A warp that issued may issue again in the following cycle. When it is the only eligible warp, it issues in consecutive cycles.
- R8: A live warp raising `bar_arrive` is parked from the next cycle. It stays ineligible until every live warp with the same block tag has parked.
- R9: When the last live warp of a block tag is parked, `bar_release` is 1 for every warp of that tag in one and the same cycle. Those warps are eligible again from the next cycle.
- R10: If the only warp of a block that has not reached the barrier is retired, the parked warps of that block are released in the cycle after the retire.
- R11: A barrier of one block tag never holds back warps of another tag. Warps of other tags keep issuing while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Bind a warp to slot `alloc_slot` |
| alloc_slot | input | WID_W | Slot index to allocate |
| alloc_block | input | BLK_W | Owning block tag of the new warp |
| retire_valid | input | 1 | Free slot `retire_slot` |
| retire_slot | input | WID_W | Slot index to retire |
| stall_fetch | input | NUM_WARPS | Per-warp instruction fetch pending |
| stall_data | input | NUM_WARPS | Per-warp data dependency stall |
| stall_exec | input | NUM_WARPS | Per-warp execution unit busy |
| bar_arrive | input | NUM_WARPS | Per-warp barrier reached, one-cycle pulse |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | WID_W | Slot index of the issued warp |
| bar_release | output | NUM_WARPS | Per-warp barrier release pulse |

## Verification
The assertions assume that the two slot-index inputs stay below `NUM_WARPS`. They also assume that allocate and retire never name the same slot in one cycle, and that `bar_arrive` is only raised for a warp that is not already parked. The bench only allocates slots it knows are free. It only retires slots it knows are live. In the pseudo-random phase it masks barrier arrivals with its own model of which warps are parked. Within those limits, the stall inputs are swept over every mask, both one cause at a time and in free combination.

// File: rtl/wis_pkg.sv
package wis_pkg;

   typedef struct packed {
      logic fetch;
      logic data;
      logic exec;
   } wis_stall_t;

   function automatic logic wis_blocked(input wis_stall_t s);
      return s.fetch | s.data | s.exec;
   endfunction

endpackage

// File: rtl/wis_slot_table.sv
module wis_slot_table #(
   parameter int NUM_WARPS = 16,
   parameter int BLK_W     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_valid,
   input  logic [WID_W-1:0]           alloc_slot,
   input  logic [BLK_W-1:0]           alloc_block,
   input  logic                       retire_valid,
   input  logic [WID_W-1:0]           retire_slot,
   output logic [NUM_WARPS-1:0]       live_o,
   output logic [NUM_WARPS*BLK_W-1:0] blk_flat_o,
   output logic [NUM_WARPS-1:0]       retire_hit_o
);

   logic [NUM_WARPS-1:0] live_q;
   logic [BLK_W-1:0]     blk_q [NUM_WARPS];

   for (genvar i = 0; i < NUM_WARPS; i++) begin : g_slot
      logic alloc_hit, retire_hit;
      assign alloc_hit  = alloc_valid  && (alloc_slot  == WID_W'(i));
      assign retire_hit = retire_valid && (retire_slot == WID_W'(i));
      assign retire_hit_o[i] = retire_hit;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q[i] <= 1'b0;
            blk_q[i]  <= '0;
         end else if (retire_hit) begin
            live_q[i] <= 1'b0;
         end else if (alloc_hit && !live_q[i]) begin
            live_q[i] <= 1'b1;
            blk_q[i]  <= alloc_block;
         end
      end

      assign blk_flat_o[i*BLK_W +: BLK_W] = blk_q[i];
   end

   assign live_o = live_q;

   a_r2_alloc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid && live_q[alloc_slot] &&
      !(retire_valid && retire_slot == alloc_slot)
      |=> live_q[$past(alloc_slot)] &&
          blk_q[$past(alloc_slot)] == $past(blk_q[alloc_slot]));

   a_r3_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |=> !live_q[$past(retire_slot)]);

endmodule

// File: rtl/wis_barrier.sv
module wis_barrier #(
   parameter int NUM_WARPS = 16,
   parameter int BLK_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_WARPS-1:0]       live_i,
   input  logic [NUM_WARPS*BLK_W-1:0] blk_flat_i,
   input  logic [NUM_WARPS-1:0]       retire_hit_i,
   input  logic [NUM_WARPS-1:0]       arrive_i,
   output logic [NUM_WARPS-1:0]       parked_o,
   output logic [NUM_WARPS-1:0]       release_o
);

   logic [NUM_WARPS-1:0] parked_q;
   logic [NUM_WARPS-1:0] grp_done;

   // A block's barrier completes when no live warp of that tag is still running
   always_comb begin
      for (int i = 0; i < NUM_WARPS; i++) begin
         grp_done[i] = 1'b1;
         for (int j = 0; j < NUM_WARPS; j++) begin
            if (live_i[j] && !parked_q[j] &&
                blk_flat_i[j*BLK_W +: BLK_W] == blk_flat_i[i*BLK_W +: BLK_W])
               grp_done[i] = 1'b0;
         end
      end
   end

   for (genvar i = 0; i < NUM_WARPS; i++) begin : g_bar
      assign release_o[i] = live_i[i] && parked_q[i] && grp_done[i];

      always_ff @(posedge clk) begin
         if (!rst_n)                        parked_q[i] <= 1'b0;
         else if (retire_hit_i[i])          parked_q[i] <= 1'b0;
         else if (release_o[i])             parked_q[i] <= 1'b0;
         else if (arrive_i[i] && live_i[i]) parked_q[i] <= 1'b1;
      end

      a_r9_release_unparks: assert property (@(posedge clk) disable iff (!rst_n)
         release_o[i] |=> !parked_q[i]);
   end

   assign parked_o = parked_q;

endmodule

// File: rtl/wis_picker.sv
module wis_picker #(
   parameter int NUM_WARPS = 16,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] elig_i,
   output logic                 valid_o,
   output logic [WID_W-1:0]     warp_o
);

   logic [WID_W-1:0] last_q;
   logic             found;
   logic [WID_W-1:0] pick;

   // Scan one past the last grant, wrapping, first eligible wins
   always_comb begin
      found = 1'b0;
      pick  = last_q;
      for (int k = 1; k <= NUM_WARPS; k++) begin
         logic [WID_W:0] idx;
         idx = {1'b0, last_q} + (WID_W+1)'(k);
         if (idx >= (WID_W+1)'(NUM_WARPS))
            idx = idx - (WID_W+1)'(NUM_WARPS);
         if (!found && elig_i[idx[WID_W-1:0]]) begin
            found = 1'b1;
            pick  = idx[WID_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     last_q <= WID_W'(NUM_WARPS - 1);
      else if (found) last_q <= pick;
   end

   assign valid_o = found;
   assign warp_o  = pick;

   a_r7_repeat_only_alone: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && warp_o == last_q |-> $countones(elig_i) == 1);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS = 16,
   parameter int BLK_W     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_valid,
   input  logic [WID_W-1:0]     alloc_slot,
   input  logic [BLK_W-1:0]     alloc_block,
   input  logic                 retire_valid,
   input  logic [WID_W-1:0]     retire_slot,
   input  logic [NUM_WARPS-1:0] stall_fetch,
   input  logic [NUM_WARPS-1:0] stall_data,
   input  logic [NUM_WARPS-1:0] stall_exec,
   input  logic [NUM_WARPS-1:0] bar_arrive,
   output logic                 issue_valid,
   output logic [WID_W-1:0]     issue_warp,
   output logic [NUM_WARPS-1:0] bar_release
);
   import wis_pkg::*;

   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("warp_issue_sched: NUM_WARPS must be at least 2");
   end
   if (BLK_W < 1) begin : g_bad_blk
      $error("warp_issue_sched: BLK_W must be at least 1");
   end

   logic [NUM_WARPS-1:0]       live;
   logic [NUM_WARPS*BLK_W-1:0] blk_flat;
   logic [NUM_WARPS-1:0]       retire_hit;
   logic [NUM_WARPS-1:0]       parked;
   logic [NUM_WARPS-1:0]       elig;
   wis_stall_t                 cause [NUM_WARPS];

   wis_slot_table #(.NUM_WARPS(NUM_WARPS), .BLK_W(BLK_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_block(alloc_block),
      .retire_valid(retire_valid), .retire_slot(retire_slot),
      .live_o(live), .blk_flat_o(blk_flat), .retire_hit_o(retire_hit)
   );

   wis_barrier #(.NUM_WARPS(NUM_WARPS), .BLK_W(BLK_W)) u_barrier (
      .clk(clk), .rst_n(rst_n),
      .live_i(live), .blk_flat_i(blk_flat), .retire_hit_i(retire_hit),
      .arrive_i(bar_arrive), .parked_o(parked), .release_o(bar_release)
   );

   for (genvar i = 0; i < NUM_WARPS; i++) begin : g_elig
      assign cause[i] = '{fetch: stall_fetch[i], data: stall_data[i], exec: stall_exec[i]};
      assign elig[i]  = live[i] && !parked[i] && !bar_arrive[i] && !wis_blocked(cause[i]);
   end

   wis_picker #(.NUM_WARPS(NUM_WARPS)) u_picker (
      .clk(clk), .rst_n(rst_n),
      .elig_i(elig), .valid_o(issue_valid), .warp_o(issue_warp)
   );

   a_r4_issue_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> live[issue_warp] && !stall_fetch[issue_warp] &&
                      !stall_data[issue_warp] && !stall_exec[issue_warp]);

   a_r8_parked_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !parked[issue_warp] && !bar_arrive[issue_warp]);

   a_r5_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |-> !issue_valid);

   a_r3_retired_silent: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid && !(alloc_valid && alloc_slot == retire_slot)
      |=> !(issue_valid && issue_warp == $past(retire_slot)));

endmodule

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
   localparam int N  = 4;
   localparam int BW = 2;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          alloc_valid = 1'b0, retire_valid = 1'b0;
   logic [IW-1:0] alloc_slot = '0, retire_slot = '0;
   logic [BW-1:0] alloc_block = '0;
   logic [N-1:0]  sf = '0, sd = '0, se = '0, arr = '0;
   logic          issue_valid;
   logic [IW-1:0] issue_warp;
   logic [N-1:0]  bar_release;

   warp_issue_sched #(.NUM_WARPS(N), .BLK_W(BW)) u_warp_issue_sched (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_block(alloc_block),
      .retire_valid(retire_valid), .retire_slot(retire_slot),
      .stall_fetch(sf), .stall_data(sd), .stall_exec(se), .bar_arrive(arr),
      .issue_valid(issue_valid), .issue_warp(issue_warp), .bar_release(bar_release)
   );

   // Reference model kept from the requirements
   logic [N-1:0]  m_live = '0, m_bar = '0;
   logic [BW-1:0] m_blk [N];
   int            m_last = N - 1;
   int            total = 0, fails = 0;
   logic          done = 1'b0;

   task automatic chk(string tag, int act, int exp, string what);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cyc(string tag);
      logic [N-1:0] elig, rel;
      int pick;
      logic found;
      #2;
      for (int i = 0; i < N; i++)
         elig[i] = m_live[i] && !m_bar[i] && !arr[i] && !sf[i] && !sd[i] && !se[i];
      found = 1'b0; pick = 0;
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (m_last + k) % N;
         if (!found && elig[idx]) begin found = 1'b1; pick = idx; end
      end
      for (int i = 0; i < N; i++) begin
         rel[i] = m_live[i] && m_bar[i];
         for (int j = 0; j < N; j++)
            if (m_live[j] && m_blk[j] == m_blk[i] && !m_bar[j]) rel[i] = 1'b0;
      end
      chk(tag, int'(issue_valid), int'(found), "issue_valid");
      if (found && issue_valid) chk(tag, int'(issue_warp), pick, "issue_warp");
      chk(tag, int'(bar_release), int'(rel), "bar_release");
      if (found) m_last = pick;
      for (int i = 0; i < N; i++) begin
         logic rh, ah;
         rh = retire_valid && retire_slot == IW'(i);
         ah = alloc_valid && alloc_slot == IW'(i);
         if (rh) m_bar[i] = 1'b0;
         else if (rel[i]) m_bar[i] = 1'b0;
         else if (arr[i] && m_live[i]) m_bar[i] = 1'b1;
         if (rh) m_live[i] = 1'b0;
         else if (ah && !m_live[i]) begin m_live[i] = 1'b1; m_blk[i] = alloc_block; end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_alloc(int slot, int blk, string tag);
      alloc_valid = 1'b1; alloc_slot = IW'(slot); alloc_block = BW'(blk);
      cyc(tag);
      alloc_valid = 1'b0;
   endtask

   task automatic do_retire(int slot, string tag);
      retire_valid = 1'b1; retire_slot = IW'(slot);
      cyc(tag);
      retire_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) m_blk[i] = '0;
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      // R1: reset state
      repeat (2) @(negedge clk);
      #2;
      chk("R1", int'(issue_valid), 0, "issue_valid in reset");
      chk("R1", int'(bar_release), 0, "bar_release in reset");
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1");
      // R2: bind warps 0,1 to block 1 and warps 2,3 to block 2
      do_alloc(0, 1, "R2");
      do_alloc(1, 1, "R2");
      do_alloc(2, 2, "R2");
      do_alloc(3, 2, "R2");
      cyc("R2");
      // R4: each stall cause alone, every mask
      for (int s = 0; s < 3; s++)
         for (int m = 0; m < 16; m++) begin
            sf = (s == 0) ? N'(m) : '0;
            sd = (s == 1) ? N'(m) : '0;
            se = (s == 2) ? N'(m) : '0;
            cyc("R4");
         end
      // R5: nothing eligible, then R6: start point kept across idle
      sf = '1; cyc("R5"); cyc("R5");
      sf = 4'b0011; cyc("R6"); cyc("R6"); cyc("R6");
      // R7: only warp 1 free
      sf = '0; sd = 4'b1101; cyc("R7"); cyc("R7"); cyc("R7");
      sd = '0; cyc("R6");
      // R2: allocate onto live slot 0 with another tag is ignored
      do_alloc(0, 2, "R2");
      // R8: warp 0 parks and waits for warp 1 of the same tag
      arr = 4'b0001; cyc("R8");
      arr = '0; cyc("R8"); cyc("R8"); cyc("R8");
      // R9: warp 1 arrives, both released together
      arr = 4'b0010; cyc("R9");
      arr = '0; cyc("R9"); cyc("R9"); cyc("R9");
      // R10: warp 2 parks, warp 3 retires, warp 2 released
      arr = 4'b0100; cyc("R10");
      arr = '0; cyc("R10");
      do_retire(3, "R3");
      cyc("R10"); cyc("R3"); cyc("R3");
      // R11: block 1 waits while block 2 keeps issuing
      arr = 4'b0001; cyc("R11");
      arr = '0; cyc("R11"); cyc("R11"); cyc("R11");
      arr = 4'b0010; cyc("R11");
      arr = '0; cyc("R11");
      do_alloc(3, 3, "R2");
      // R6: mixed pseudo-random sweep with occasional retire and reallocation
      lfsr = 16'hACE1;
      for (int c = 0; c < 3000; c++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sf  = lfsr[3:0] & lfsr[7:4];
         sd  = lfsr[11:8] & lfsr[15:12] & lfsr[3:0];
         se  = lfsr[6:3] & lfsr[10:7];
         arr = (lfsr[2:0] == 3'd5) ? (N'(1) << lfsr[9:8]) & m_live & ~m_bar : '0;
         if (lfsr[14:11] == 4'hF && m_live[lfsr[5:4]]) begin
            retire_valid = 1'b1; retire_slot = lfsr[5:4];
         end else if (!m_live[lfsr[1:0]]) begin
            alloc_valid = 1'b1; alloc_slot = lfsr[1:0]; alloc_block = lfsr[13:12];
         end
         if (retire_valid && alloc_valid) alloc_valid = 1'b0;
         cyc("R6");
         retire_valid = 1'b0; alloc_valid = 1'b0;
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule